// File: doc/BRIEF.md
# Debug Port Register Front End

This block is the register layer that sits behind a serial debug link. Each cycle it may accept one access request: it says whether the access targets the debug port itself or a downstream access port, whether it is a read or a write, a 2-bit register index and 32 bits of write data. One cycle later it returns a 3-bit acknowledge and read data.

Debug port accesses hit a small set of registers: a fixed identifier, an abort/clear register, a control and status word, a selector, a resend register and a read buffer. The control word also holds three request/acknowledge handshake pairs for debug reset, debug power and system power. Access port accesses go out through a valid/ready port. Reads from the access port are posted, so each one returns the value fetched by the read before it. Error conditions are kept in sticky flags. While any of them is set, every later access port request is refused until software clears the flag through the abort register.

The block contains no line protocol; the serial or scan front end feeds it requests.

Top module: `dbg_port_regs`

## Requirements
- R1: Every request gets a response in the cycle after it, with an acknowledge of OK = 3'b001, WAIT = 3'b010 or FAULT = 3'b100. Every debug port access returns OK.
- R2: After reset, the selector is zero, all sticky flags are clear, all request outputs are low, the turnaround is 1 cycle and the read buffer is zero. A debug port read of index 0 returns the ID_VALUE parameter.
- R3: The control word sits at index 1 when the selector's port bank is 0. Its bit 0 is the overrun-detect enable, bit 1 the sticky overrun, bit 5 the sticky error and bit 6 the read-ok flag. Bits 26, 28 and 30 are read/write requests that drive the debug-reset, debug-power and system-power request outputs. Bits 27, 29 and 31 read back the matching acknowledge inputs. All other bits read 0, and writes to the status bits are ignored.
- R4: A write to index 2 loads the selector. Bits [31:24] drive the access port select output, bits [7:4] give the access port bank placed in `ap_reg_o[5:2]`, and bits [3:0] give the port bank that chooses the register at index 1.
- R5: With port bank 1, index 1 is a link control register. Its bits [9:8] set `trn_cycles_o` to that field plus 1, which gives 1 to 4 cycles. With any port bank other than 0 or 1, index 1 reads 0 and writes to it are ignored.
- R6: An access port request with no sticky flag set raises `ap_valid_o` in the same cycle, together with the direction, select, `{bank, index}` register and write data. If `ap_ready_i` is high, the request is acknowledged OK.
- R7: An access port request that sees `ap_ready_i` low is acknowledged WAIT. It also sets the sticky overrun flag, but only while overrun detection is enabled.
- R8: While sticky error or sticky overrun is set, an access port request is acknowledged FAULT and `ap_valid_o` stays low.
- R9: An accepted access port request with `ap_err_i` high is still acknowledged OK, and it sets the sticky error flag.
- R10: An accepted access port read returns the previous read buffer contents and loads `ap_rdata_i` into the buffer. It sets read-ok, or clears it on error. A WAIT or FAULT read clears read-ok. A debug port read of index 3 returns the buffer and leaves it unchanged.
- R11: A write to index 0 is the abort register. Bit 0 pulses `ap_abort_o` in that cycle, bit 2 clears the sticky error flag and bit 4 clears the sticky overrun flag.
- R12: A read of index 2 returns the data of the most recent OK read that was not itself a read of index 2, and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ap_i | input | 1 | 1 = access port, 0 = debug port |
| req_write_i | input | 1 | 1 = write |
| req_addr_i | input | 2 | Register index (byte offset / 4) |
| req_wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | Response strobe, one cycle after the request |
| resp_ack_o | output | 3 | Acknowledge code |
| resp_rdata_o | output | 32 | Read data |
| ap_valid_o | output | 1 | Access port request valid |
| ap_ready_i | input | 1 | Access port can accept |
| ap_write_o | output | 1 | Access port direction |
| ap_sel_o | output | 8 | Access port select |
| ap_reg_o | output | 6 | Access port register {bank, index} |
| ap_wdata_o | output | 32 | Access port write data |
| ap_rdata_i | input | 32 | Access port read data, valid with ready |
| ap_err_i | input | 1 | Access port error, valid with ready |
| ap_abort_o | output | 1 | Abort pulse to the access port |
| dbg_rst_req_o | output | 1 | Debug reset request |
| dbg_rst_ack_i | input | 1 | Debug reset acknowledge |
| dbg_pwr_req_o | output | 1 | Debug power-up request |
| dbg_pwr_ack_i | input | 1 | Debug power-up acknowledge |
| sys_pwr_req_o | output | 1 | System power-up request |
| sys_pwr_ack_i | input | 1 | System power-up acknowledge |
| trn_cycles_o | output | 3 | Turnaround length in cycles |

## Verification
The properties assume that the access port completes a transfer in the cycle `ap_ready_i` is high, and that its read data and error flag are meaningful only in that cycle. They also assume at most one request per cycle, with the request fields stable while `req_valid_i` is high. The stimulus drives every request for exactly one cycle, changes inputs only on the falling edge, and holds the acknowledge inputs constant across each access. The random traffic often writes the abort register, so sticky faults clear often enough for access port traffic to keep flowing.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;
  localparam int DW      = 32;
  localparam int SEL_W   = 8;
  localparam int BANK_W  = 4;
  localparam int N_PAIRS = 3;
  localparam int PAIR_LO = 26;

  typedef enum logic [2:0] {
    ACK_OK    = 3'b001,
    ACK_WAIT  = 3'b010,
    ACK_FAULT = 3'b100
  } ack_e;

  localparam logic [1:0] IDX_ID_ABORT = 2'd0;
  localparam logic [1:0] IDX_CTRL     = 2'd1;
  localparam logic [1:0] IDX_SEL_RSND = 2'd2;
  localparam logic [1:0] IDX_RDBUF    = 2'd3;

  typedef struct packed {
    logic [SEL_W-1:0]  ap_sel;
    logic [BANK_W-1:0] ap_bank;
    logic [BANK_W-1:0] dp_bank;
  } sel_t;
endpackage

// File: rtl/dbg_port_ctrl.sv
module dbg_port_ctrl import dbg_port_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_ctrl_i,
  input  logic               orun_en_wd_i,
  input  logic [N_PAIRS-1:0] req_wd_i,
  input  logic               wr_link_i,
  input  logic [1:0]         trn_wd_i,
  input  logic               clr_err_i,
  input  logic               clr_orun_i,
  input  logic               set_err_i,
  input  logic               set_orun_i,
  input  logic               rdok_upd_i,
  input  logic               rdok_val_i,
  input  logic [N_PAIRS-1:0] pair_ack_i,
  output logic [N_PAIRS-1:0] pair_req_o,
  output logic               orun_en_o,
  output logic               st_err_o,
  output logic               st_orun_o,
  output logic [DW-1:0]      ctrl_rd_o,
  output logic [DW-1:0]      link_rd_o,
  output logic [2:0]         trn_cycles_o
);
  logic       orun_en_q, st_err_q, st_orun_q, rdok_q;
  logic [1:0] trn_q;
  logic [N_PAIRS-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      orun_en_q <= 1'b0;
      st_err_q  <= 1'b0;
      st_orun_q <= 1'b0;
      rdok_q    <= 1'b0;
      trn_q     <= 2'd0;
    end else begin
      if (wr_ctrl_i) orun_en_q <= orun_en_wd_i;
      if (set_err_i) st_err_q <= 1'b1;
      else if (clr_err_i) st_err_q <= 1'b0;
      if (set_orun_i) st_orun_q <= 1'b1;
      else if (clr_orun_i) st_orun_q <= 1'b0;
      if (rdok_upd_i) rdok_q <= rdok_val_i;
      if (wr_link_i) trn_q <= trn_wd_i;
    end
  end

  for (genvar gi = 0; gi < N_PAIRS; gi++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q[gi] <= 1'b0;
      else if (wr_ctrl_i) req_q[gi] <= req_wd_i[gi];
    end
  end

  always_comb begin
    ctrl_rd_o    = '0;
    ctrl_rd_o[0] = orun_en_q;
    ctrl_rd_o[1] = st_orun_q;
    ctrl_rd_o[5] = st_err_q;
    ctrl_rd_o[6] = rdok_q;
    for (int i = 0; i < N_PAIRS; i++) begin
      ctrl_rd_o[PAIR_LO+2*i]   = req_q[i];
      ctrl_rd_o[PAIR_LO+2*i+1] = pair_ack_i[i];
    end
  end

  assign link_rd_o    = {{(DW-10){1'b0}}, trn_q, 8'h00};
  assign trn_cycles_o = {1'b0, trn_q} + 3'd1;
  assign pair_req_o   = req_q;
  assign orun_en_o    = orun_en_q;
  assign st_err_o     = st_err_q;
  assign st_orun_o    = st_orun_q;
endmodule

// File: rtl/dbg_port_ap_fwd.sv
module dbg_port_ap_fwd import dbg_port_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          write_i,
  input  logic          sticky_i,
  input  logic          orun_en_i,
  input  logic          ap_ready_i,
  input  logic          ap_err_i,
  input  logic [DW-1:0] ap_rdata_i,
  output logic          ap_valid_o,
  output ack_e          ack_o,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] rdbuf_o,
  output logic          set_err_o,
  output logic          set_orun_o,
  output logic          rdok_upd_o,
  output logic          rdok_val_o
);
  logic [DW-1:0] rdbuf_q;
  logic          accepted, rd_acc;

  assign ap_valid_o = go_i & ~sticky_i;
  assign accepted   = ap_valid_o & ap_ready_i;
  assign rd_acc     = accepted & ~write_i;

  always_comb begin
    if (sticky_i)         ack_o = ACK_FAULT;
    else if (!ap_ready_i) ack_o = ACK_WAIT;
    else                  ack_o = ACK_OK;
  end

  // posted read: hand back the previous fetch, keep the new one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdbuf_q <= '0;
    else if (rd_acc) rdbuf_q <= ap_rdata_i;
  end

  assign rd_data_o  = rd_acc ? rdbuf_q : '0;
  assign rdbuf_o    = rdbuf_q;
  assign set_err_o  = accepted & ap_err_i;
  assign set_orun_o = ap_valid_o & ~ap_ready_i & orun_en_i;
  assign rdok_upd_o = go_i & ~write_i;
  assign rdok_val_o = rd_acc & ~ap_err_i;
endmodule

// File: rtl/dbg_port_regs.sv
module dbg_port_regs import dbg_port_pkg::*; #(
  parameter logic [DW-1:0] ID_VALUE = 32'h2BA0_1477
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_ap_i,
  input  logic          req_write_i,
  input  logic [1:0]    req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          resp_valid_o,
  output logic [2:0]    resp_ack_o,
  output logic [DW-1:0] resp_rdata_o,
  output logic          ap_valid_o,
  input  logic          ap_ready_i,
  output logic          ap_write_o,
  output logic [SEL_W-1:0] ap_sel_o,
  output logic [BANK_W+1:0] ap_reg_o,
  output logic [DW-1:0] ap_wdata_o,
  input  logic [DW-1:0] ap_rdata_i,
  input  logic          ap_err_i,
  output logic          ap_abort_o,
  output logic          dbg_rst_req_o,
  input  logic          dbg_rst_ack_i,
  output logic          dbg_pwr_req_o,
  input  logic          dbg_pwr_ack_i,
  output logic          sys_pwr_req_o,
  input  logic          sys_pwr_ack_i,
  output logic [2:0]    trn_cycles_o
);
  sel_t          sel_q;
  logic          dp_wr, dp_rd, ap_go;
  logic          wr_abort, wr_ctrl, wr_link, wr_sel;
  logic          st_err, st_orun, orun_en;
  logic          set_err, set_orun, rdok_upd, rdok_val;
  logic [N_PAIRS-1:0] pair_req;
  logic [DW-1:0] ctrl_rd, link_rd, ap_rd, rdbuf, dp_rdata, resend_q;
  ack_e          ap_ack;

  assign dp_wr    = req_valid_i & ~req_ap_i &  req_write_i;
  assign dp_rd    = req_valid_i & ~req_ap_i & ~req_write_i;
  assign ap_go    = req_valid_i &  req_ap_i;
  assign wr_abort = dp_wr & (req_addr_i == IDX_ID_ABORT);
  assign wr_ctrl  = dp_wr & (req_addr_i == IDX_CTRL) & (sel_q.dp_bank == 4'd0);
  assign wr_link  = dp_wr & (req_addr_i == IDX_CTRL) & (sel_q.dp_bank == 4'd1);
  assign wr_sel   = dp_wr & (req_addr_i == IDX_SEL_RSND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (wr_sel) sel_q <= {req_wdata_i[31:24], req_wdata_i[7:4], req_wdata_i[3:0]};
  end

  dbg_port_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ctrl_i    (wr_ctrl),
    .orun_en_wd_i (req_wdata_i[0]),
    .req_wd_i     ({req_wdata_i[30], req_wdata_i[28], req_wdata_i[26]}),
    .wr_link_i    (wr_link),
    .trn_wd_i     (req_wdata_i[9:8]),
    .clr_err_i    (wr_abort & req_wdata_i[2]),
    .clr_orun_i   (wr_abort & req_wdata_i[4]),
    .set_err_i    (set_err),
    .set_orun_i   (set_orun),
    .rdok_upd_i   (rdok_upd),
    .rdok_val_i   (rdok_val),
    .pair_ack_i   ({sys_pwr_ack_i, dbg_pwr_ack_i, dbg_rst_ack_i}),
    .pair_req_o   (pair_req),
    .orun_en_o    (orun_en),
    .st_err_o     (st_err),
    .st_orun_o    (st_orun),
    .ctrl_rd_o    (ctrl_rd),
    .link_rd_o    (link_rd),
    .trn_cycles_o (trn_cycles_o)
  );

  dbg_port_ap_fwd u_ap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (ap_go),
    .write_i    (req_write_i),
    .sticky_i   (st_err | st_orun),
    .orun_en_i  (orun_en),
    .ap_ready_i (ap_ready_i),
    .ap_err_i   (ap_err_i),
    .ap_rdata_i (ap_rdata_i),
    .ap_valid_o (ap_valid_o),
    .ack_o      (ap_ack),
    .rd_data_o  (ap_rd),
    .rdbuf_o    (rdbuf),
    .set_err_o  (set_err),
    .set_orun_o (set_orun),
    .rdok_upd_o (rdok_upd),
    .rdok_val_o (rdok_val)
  );

  always_comb begin
    unique case (req_addr_i)
      IDX_ID_ABORT: dp_rdata = ID_VALUE;
      IDX_CTRL: begin
        if (sel_q.dp_bank == 4'd0)      dp_rdata = ctrl_rd;
        else if (sel_q.dp_bank == 4'd1) dp_rdata = link_rd;
        else                            dp_rdata = '0;
      end
      IDX_SEL_RSND: dp_rdata = resend_q;
      default:      dp_rdata = rdbuf;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_ack_o   <= ACK_OK;
      resp_rdata_o <= '0;
      resend_q     <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_ack_o   <= req_ap_i ? ap_ack : ACK_OK;
      if (dp_rd)      resp_rdata_o <= dp_rdata;
      else if (ap_go) resp_rdata_o <= ap_rd;
      else            resp_rdata_o <= '0;
      if (dp_rd && req_addr_i != IDX_SEL_RSND) resend_q <= dp_rdata;
      else if (rdok_upd && ap_valid_o && ap_ready_i) resend_q <= ap_rd;
    end
  end

  assign ap_write_o    = req_write_i;
  assign ap_sel_o      = sel_q.ap_sel;
  assign ap_reg_o      = {sel_q.ap_bank, req_addr_i};
  assign ap_wdata_o    = req_wdata_i;
  assign ap_abort_o    = wr_abort & req_wdata_i[0];
  assign dbg_rst_req_o = pair_req[0];
  assign dbg_pwr_req_o = pair_req[1];
  assign sys_pwr_req_o = pair_req[2];
endmodule

// File: rtl/dbg_port_checker.sv
module dbg_port_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ap_i,
  input logic       req_write_i,
  input logic [1:0] req_addr_i,
  input logic       resp_valid_o,
  input logic [2:0] resp_ack_o,
  input logic       ap_valid_o,
  input logic       ap_ready_i,
  input logic       ap_err_i,
  input logic       dbg_pwr_req_o,
  input logic       st_err_i,
  input logic       st_orun_i
);
  assert_ack_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $countones(resp_ack_o) == 1);

  assert_resp_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  assert_pwr_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_ap_i && req_write_i && req_addr_i == 2'd1) |=> $stable(dbg_pwr_req_o));

  assert_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ap_i && ap_valid_o && !ap_ready_i) |=> resp_ack_o == 3'b010);

  assert_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ap_i && (st_err_i || st_orun_i)) |=> resp_ack_o == 3'b100);

  assert_no_fwd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_err_i || st_orun_i) |-> !ap_valid_o);

  assert_err_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_err_i) |-> $past(ap_valid_o && ap_ready_i && ap_err_i));
endmodule

bind dbg_port_regs dbg_port_checker i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ap_i      (req_ap_i),
  .req_write_i   (req_write_i),
  .req_addr_i    (req_addr_i),
  .resp_valid_o  (resp_valid_o),
  .resp_ack_o    (resp_ack_o),
  .ap_valid_o    (ap_valid_o),
  .ap_ready_i    (ap_ready_i),
  .ap_err_i      (ap_err_i),
  .dbg_pwr_req_o (dbg_pwr_req_o),
  .st_err_i      (st_err),
  .st_orun_i     (st_orun)
);

// File: tb/test_dbg_port_regs.sv
module test_dbg_port_regs;
  localparam logic [31:0] ID = 32'h2BA0_1477;
  localparam logic [2:0] E_OK = 3'b001, E_WAIT = 3'b010, E_FAULT = 3'b100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ap = 0, req_write = 0;
  logic [1:0] req_addr = 0;
  logic [31:0] req_wdata = 0, ap_rdata = 0;
  logic ap_ready = 0, ap_err = 0;
  logic rst_ack = 0, pwr_ack = 0, sys_ack = 0;
  logic resp_valid, ap_valid, ap_write, ap_abort;
  logic [2:0] resp_ack, trn;
  logic [31:0] resp_rdata, ap_wdata;
  logic [7:0] ap_sel;
  logic [5:0] ap_reg;
  logic rst_req, pwr_req, sys_req;

  int n_chk = 0, n_fail = 0;

  // bench model
  logic m_oen, m_orun, m_err, m_rdok;
  logic [2:0] m_req;
  logic [1:0] m_trn;
  logic [7:0] m_apsel;
  logic [3:0] m_apbank, m_dpbank;
  logic [31:0] m_rdbuf, m_last;

  always #10 clk = ~clk;

  dbg_port_regs #(.ID_VALUE(ID)) i_dbg_port_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ap_i(req_ap), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_ack_o(resp_ack), .resp_rdata_o(resp_rdata),
    .ap_valid_o(ap_valid), .ap_ready_i(ap_ready), .ap_write_o(ap_write),
    .ap_sel_o(ap_sel), .ap_reg_o(ap_reg), .ap_wdata_o(ap_wdata),
    .ap_rdata_i(ap_rdata), .ap_err_i(ap_err), .ap_abort_o(ap_abort),
    .dbg_rst_req_o(rst_req), .dbg_rst_ack_i(rst_ack),
    .dbg_pwr_req_o(pwr_req), .dbg_pwr_ack_i(pwr_ack),
    .sys_pwr_req_o(sys_req), .sys_pwr_ack_i(sys_ack),
    .trn_cycles_o(trn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_val();
    logic [31:0] v = '0;
    v[0] = m_oen; v[1] = m_orun; v[5] = m_err; v[6] = m_rdok;
    v[26] = m_req[0]; v[27] = rst_ack;
    v[28] = m_req[1]; v[29] = pwr_ack;
    v[30] = m_req[2]; v[31] = sys_ack;
    return v;
  endfunction

  task automatic model_reset();
    m_oen = 0; m_orun = 0; m_err = 0; m_rdok = 0; m_req = 0; m_trn = 0;
    m_apsel = 0; m_apbank = 0; m_dpbank = 0; m_rdbuf = 0; m_last = 0;
  endtask

  task automatic step(input bit ap, input bit wr, input logic [1:0] addr,
                      input logic [31:0] wd, input bit rdy, input bit err,
                      input logic [31:0] aprd, input string tag);
    logic [2:0] e_ack;
    logic [31:0] e_rd;
    bit e_val;
    @(negedge clk);
    req_valid = 1; req_ap = ap; req_write = wr; req_addr = addr; req_wdata = wd;
    ap_ready = rdy; ap_err = err; ap_rdata = aprd;
    #1;
    e_val = ap && !(m_err || m_orun);
    chk({tag, " ap_valid (R6/R8)"}, {31'd0, ap_valid}, {31'd0, e_val});
    if (e_val) begin
      chk({tag, " ap_sel R4"}, {24'd0, ap_sel}, {24'd0, m_apsel});
      chk({tag, " ap_reg R4"}, {26'd0, ap_reg}, {26'd0, m_apbank, addr});
      chk({tag, " ap fields R6"}, {ap_wdata[30:0], ap_write}, {wd[30:0], wr});
    end
    if (!ap && wr && addr == 2'd0)
      chk({tag, " abort pulse R11"}, {31'd0, ap_abort}, {31'd0, wd[0]});
    e_ack = E_OK; e_rd = '0;
    if (ap) begin
      if (m_err || m_orun) begin
        e_ack = E_FAULT;
        if (!wr) m_rdok = 0;
      end else if (!rdy) begin
        e_ack = E_WAIT;
        if (m_oen) m_orun = 1;
        if (!wr) m_rdok = 0;
      end else begin
        if (err) m_err = 1;
        if (!wr) begin
          e_rd = m_rdbuf; m_rdbuf = aprd; m_rdok = !err; m_last = e_rd;
        end
      end
    end else if (wr) begin
      case (addr)
        2'd0: begin if (wd[2]) m_err = 0; if (wd[4]) m_orun = 0; end
        2'd1: begin
          if (m_dpbank == 0) begin m_oen = wd[0]; m_req = {wd[30], wd[28], wd[26]}; end
          else if (m_dpbank == 1) m_trn = wd[9:8];
        end
        2'd2: begin m_apsel = wd[31:24]; m_apbank = wd[7:4]; m_dpbank = wd[3:0]; end
        default: ;
      endcase
    end else begin
      case (addr)
        2'd0: e_rd = ID;
        2'd1: e_rd = (m_dpbank == 0) ? ctrl_val() : (m_dpbank == 1) ? {22'd0, m_trn, 8'd0} : 32'd0;
        2'd2: e_rd = m_last;
        default: e_rd = m_rdbuf;
      endcase
      if (addr != 2'd2) m_last = e_rd;
    end
    @(posedge clk);
    #2;
    chk({tag, " resp_valid R1"}, {31'd0, resp_valid}, 32'd1);
    chk({tag, " ack R1"}, {29'd0, resp_ack}, {29'd0, e_ack});
    chk({tag, " rdata"}, resp_rdata, e_rd);
    chk({tag, " requests R3"}, {29'd0, sys_req, pwr_req, rst_req}, {29'd0, m_req});
    chk({tag, " turnaround R5"}, {29'd0, trn}, {29'd0, 1'b0, m_trn} + 32'd1);
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R2 requests", {29'd0, sys_req, pwr_req, rst_req}, 32'd0);
    chk("R2 trn", {29'd0, trn}, 32'd1);
    chk("R2 sel", {24'd0, ap_sel}, 32'd0);
    rst_n = 1;
    step(0, 0, 2'd0, 0, 1, 0, 0, "R2 id read");
    step(0, 0, 2'd3, 0, 1, 0, 0, "R2 rdbuf read");
    step(0, 0, 2'd1, 0, 1, 0, 0, "R2 ctrl read");
    // R3 control word
    step(0, 1, 2'd1, 32'h5000_00F3, 1, 0, 0, "R3 ctrl write");
    rst_ack = 1; sys_ack = 1;
    step(0, 0, 2'd1, 0, 1, 0, 0, "R3 ctrl read");
    // R4 / R6 select and forward
    step(0, 1, 2'd2, 32'h5A00_0030, 1, 0, 0, "R4 select");
    step(1, 1, 2'd1, 32'hDEAD_BEEF, 1, 0, 0, "R6 ap write");
    // R10 posted reads
    step(1, 0, 2'd2, 0, 1, 0, 32'h0000_CAFE, "R10 ap read 1");
    step(1, 0, 2'd3, 0, 1, 0, 32'h0000_1234, "R10 ap read 2");
    step(0, 0, 2'd3, 0, 1, 0, 0, "R10 rdbuf");
    step(0, 0, 2'd3, 0, 1, 0, 0, "R10 rdbuf again");
    step(0, 0, 2'd1, 0, 1, 0, 0, "R10 readok");
    // R12 resend
    step(0, 0, 2'd2, 0, 1, 0, 0, "R12 resend");
    step(0, 0, 2'd2, 0, 1, 0, 0, "R12 resend again");
    // R7 / R8 / R11 overrun
    step(1, 0, 2'd0, 0, 0, 0, 32'h1, "R7 wait");
    step(1, 1, 2'd0, 32'h1, 1, 0, 0, "R8 fault orun");
    step(0, 0, 2'd1, 0, 1, 0, 0, "R7 orun flag");
    step(0, 1, 2'd0, 32'h11, 1, 0, 0, "R11 clear orun");
    step(1, 1, 2'd0, 32'h2, 1, 0, 0, "R11 after clear");
    // R9 error
    step(1, 1, 2'd1, 32'h3, 1, 1, 0, "R9 err accepted");
    step(1, 0, 2'd1, 0, 1, 0, 32'h9, "R8 fault err");
    step(0, 0, 2'd1, 0, 1, 0, 0, "R9 err flag");
    step(0, 1, 2'd0, 32'h04, 1, 0, 0, "R11 clear err");
    // R7 wait without detect
    step(0, 1, 2'd1, 32'h1000_0000, 1, 0, 0, "R7 disable detect");
    step(1, 0, 2'd0, 0, 0, 0, 0, "R7 wait no flag");
    step(1, 0, 2'd0, 0, 1, 0, 32'h77, "R7 no fault");
    // R5 link control
    step(0, 1, 2'd2, 32'h0000_0001, 1, 0, 0, "R5 bank1");
    step(0, 1, 2'd1, 32'h0000_0300, 1, 0, 0, "R5 trn write");
    step(0, 0, 2'd1, 0, 1, 0, 0, "R5 trn read");
    step(0, 1, 2'd2, 32'h0000_0002, 1, 0, 0, "R5 bank2");
    step(0, 1, 2'd1, 32'hFFFF_FFFF, 1, 0, 0, "R5 ignored write");
    step(0, 0, 2'd1, 0, 1, 0, 0, "R5 bank2 read");
    step(0, 1, 2'd2, 32'h0000_0000, 1, 0, 0, "R4 bank0");
    // random mix
    for (int i = 0; i < 600; i++) begin
      bit ap, wr;
      logic [1:0] addr;
      logic [31:0] wd;
      ap = $urandom % 2; wr = $urandom % 2; addr = 2'($urandom % 4);
      wd = $urandom;
      if (!ap && wr && addr == 2'd2) wd = wd & 32'hFF00_00F3;
      if (i % 7 == 0) begin ap = 0; wr = 1; addr = 0; wd = wd | 32'h14; end
      if (i % 13 == 0) begin rst_ack = $urandom % 2; pwr_ack = $urandom % 2; sys_ack = $urandom % 2; end
      step(ap, wr, addr, wd, ($urandom % 4) != 0, ($urandom % 8) == 0, $urandom, "R1 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule